// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block is the register half of a scoreboard. It holds one row per function unit and one column per architectural register. Each cell notes whether that unit still has to read the register as a source, and whether it will write it as a destination. A third bit in each cell marks the unit that produces the newest value of the register. Only one unit per column may hold that mark, so the mark renames the register to a unit without a separate physical register file or a tag lookup.

The issue stage presents a one-hot unit select and one-hot source and destination vectors. In the same cycle the block answers with a one-hot wait-on-unit vector for each source, and raises a stall if the chosen unit is still busy. An accepted issue loads the unit's row. It also moves the newest-writer mark of the destination column onto that row. When a unit finishes write-back it clears its own row. From then on its registers are read from the register file again. The column-wise OR of the rows drives one-hot read-pending and write-pending vectors per register, ready for a register file that takes per-register enables.

Top module: `fu_reg_dep_matrix`

## Requirements
- R1: After reset every unit is idle, `rd_pending` and `wr_pending` are all zero, and both wait vectors are zero.
- R2: An issue is accepted when `iss_valid` is high, `iss_fu` is non-zero and the chosen unit is idle. One cycle later that unit's bit in `fu_busy` is 1, the bits of `iss_src_a | iss_src_b` are set in `rd_pending`, and the bits of `iss_dst` are set in `wr_pending`.
- R3: In any register column, at most one unit holds the newest-writer mark. An accepted issue with destination register r clears the mark in every other row of column r, and one cycle later the mark sits in the issuing unit's row.
- R4: In the same cycle, combinationally, `wait_a` (resp. `wait_b`) has bit f set exactly when unit f holds the newest-writer mark of a register in `iss_src_a` (resp. `iss_src_b`). The vector is all zeros when that register has no pending writer. This lookup does not depend on `iss_valid`.
- R5: A unit whose bit is set in `wb_fu` in the current cycle is left out of both wait vectors in that cycle, because its result reaches the register file at that edge.
- R6: When `wb_fu` names a busy unit, one cycle later that unit is idle and its row is empty. Its read and write bits leave the pending vectors unless another unit still holds them, and later readers of its registers get a zero wait vector.
- R7: An issue to a busy unit raises `iss_stall` in the same cycle and changes no state.
- R8: With `iss_valid` low, the issue inputs change no state.
- R9: If an issue names the same register as a source and as its destination, the source waits on the previous newest writer of that register, not on the issuing unit.
- R10: After MUL r1,r2,r3 on unit 2, ADD r4,r1,r3 on unit 0 and ADD r1,r5,r6 on unit 1, the second instruction waits on unit 2. A later reader of r1 waits on unit 1.
- R11: A `wb_fu` bit for an idle unit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request this cycle |
| iss_fu | input | FU_N | One-hot function unit receiving the instruction |
| iss_src_a | input | REG_N | One-hot first source register (zero if unused) |
| iss_src_b | input | REG_N | One-hot second source register (zero if unused) |
| iss_dst | input | REG_N | One-hot destination register (zero if none) |
| wb_fu | input | FU_N | Units completing write-back this cycle |
| iss_stall | output | 1 | Issue refused: the selected unit is busy |
| wait_a | output | FU_N | One-hot unit the first source must wait on |
| wait_b | output | FU_N | One-hot unit the second source must wait on |
| rd_pending | output | REG_N | Per-register pending-read enables |
| wr_pending | output | REG_N | Per-register pending-write enables |
| fu_busy | output | FU_N | Units holding an issued instruction |

## Verification
The block has results on two timescales. `iss_stall` and both wait vectors are combinational on the issue inputs and the current matrix, so they are due in the same cycle the stimulus is driven. `fu_busy`, `rd_pending` and `wr_pending` come from the row registers, so they are due one clock edge later. The driver applies each stimulus just after a falling edge. It queues one same-cycle item and one next-cycle item, each tagged with the cycle it is due in, and the monitor compares in the low phase of that cycle. The expected values come from a requirement-level model of the rows held in the bench, which is updated after the same-cycle expectation is taken from the pre-issue state.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
    localparam int DEF_FU_N  = 8;
    localparam int DEF_REG_N = 32;
endpackage

// File: rtl/fdm_row.sv
module fdm_row #(
    parameter int REG_N = fdm_pkg::DEF_REG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             retire,
    input  logic [REG_N-1:0] src_vec,
    input  logic [REG_N-1:0] dst_vec,
    input  logic [REG_N-1:0] kill_vec,
    output logic             busy,
    output logic [REG_N-1:0] need_rd,
    output logic [REG_N-1:0] need_wr,
    output logic [REG_N-1:0] newest
);
    typedef struct packed {
        logic             busy;
        logic [REG_N-1:0] nr;
        logic [REG_N-1:0] nw;
        logic [REG_N-1:0] lw;
    } row_t;

    row_t row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (retire && row_q.busy) begin
            row_d = '0;
        end else if (load) begin
            row_d.busy = 1'b1;
            row_d.nr   = src_vec;
            row_d.nw   = dst_vec;
            row_d.lw   = dst_vec;
        end else begin
            row_d.lw = row_q.lw & ~kill_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign busy    = row_q.busy;
    assign need_rd = row_q.nr;
    assign need_wr = row_q.nw;
    assign newest  = row_q.lw;

    // R6: a retiring busy row is empty on the next cycle
    p_retire_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && busy) |=> (!busy && newest == '0 && need_wr == '0));

    // R2: a loaded row is busy with the issued destination
    p_load_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && need_wr == $past(dst_vec)));

    // R3: the newest-writer mark never sits outside the row's destinations
    p_mark_in_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (newest & ~need_wr) == '0);
endmodule

// File: rtl/fdm_wait_sel.sv
module fdm_wait_sel #(
    parameter int FU_N  = fdm_pkg::DEF_FU_N,
    parameter int REG_N = fdm_pkg::DEF_REG_N
) (
    input  logic [FU_N-1:0][REG_N-1:0] mark_rows,
    input  logic [REG_N-1:0]           src_vec,
    input  logic [FU_N-1:0]            exclude,
    output logic [FU_N-1:0]            wait_on
);
    for (genvar f = 0; f < FU_N; f++) begin : g_fu
        assign wait_on[f] = (|(mark_rows[f] & src_vec)) & ~exclude[f];
    end
endmodule

// File: rtl/fu_reg_dep_matrix.sv
module fu_reg_dep_matrix #(
    parameter int FU_N  = fdm_pkg::DEF_FU_N,
    parameter int REG_N = fdm_pkg::DEF_REG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [FU_N-1:0]  iss_fu,
    input  logic [REG_N-1:0] iss_src_a,
    input  logic [REG_N-1:0] iss_src_b,
    input  logic [REG_N-1:0] iss_dst,
    input  logic [FU_N-1:0]  wb_fu,
    output logic             iss_stall,
    output logic [FU_N-1:0]  wait_a,
    output logic [FU_N-1:0]  wait_b,
    output logic [REG_N-1:0] rd_pending,
    output logic [REG_N-1:0] wr_pending,
    output logic [FU_N-1:0]  fu_busy
);
    logic [FU_N-1:0][REG_N-1:0] nr_rows, nw_rows, lw_rows;
    logic                       accept;
    logic [REG_N-1:0]           kill_vec;

    assign iss_stall = iss_valid && ((iss_fu & fu_busy) != '0);
    assign accept    = iss_valid && (iss_fu != '0) && !iss_stall;
    assign kill_vec  = accept ? iss_dst : '0;

    for (genvar f = 0; f < FU_N; f++) begin : g_row
        fdm_row #(.REG_N(REG_N)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept && iss_fu[f]),
            .retire   (wb_fu[f]),
            .src_vec  (iss_src_a | iss_src_b),
            .dst_vec  (iss_dst),
            .kill_vec (kill_vec),
            .busy     (fu_busy[f]),
            .need_rd  (nr_rows[f]),
            .need_wr  (nw_rows[f]),
            .newest   (lw_rows[f])
        );
    end

    fdm_wait_sel #(.FU_N(FU_N), .REG_N(REG_N)) u_wait_a (
        .mark_rows (lw_rows),
        .src_vec   (iss_src_a),
        .exclude   (wb_fu),
        .wait_on   (wait_a)
    );

    fdm_wait_sel #(.FU_N(FU_N), .REG_N(REG_N)) u_wait_b (
        .mark_rows (lw_rows),
        .src_vec   (iss_src_b),
        .exclude   (wb_fu),
        .wait_on   (wait_b)
    );

    always_comb begin
        rd_pending = '0;
        wr_pending = '0;
        for (int f = 0; f < FU_N; f++) begin
            rd_pending = rd_pending | nr_rows[f];
            wr_pending = wr_pending | nw_rows[f];
        end
    end

    for (genvar r = 0; r < REG_N; r++) begin : g_col
        logic [FU_N-1:0] col;
        always_comb begin
            for (int f = 0; f < FU_N; f++) col[f] = lw_rows[f][r];
        end

        // R3: one newest writer per register column
        p_col_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));

        // R3: an accepted destination moves the mark to the issuing unit
        p_mark_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && iss_dst[r]) |=> (col == $past(iss_fu)));
    end

    // R4: each wait vector names at most one unit
    p_wait_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wait_a) && $onehot0(wait_b));

    // R7: a stalled issue with no write-back leaves the busy set unchanged
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_stall && wb_fu == '0) |=> (fu_busy == $past(fu_busy)));

    // R8: no request and no write-back keeps the pending vectors
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid && wb_fu == '0) |=> ($stable(rd_pending) && $stable(wr_pending)));
endmodule

// File: tb/tb_fu_reg_dep_matrix.sv
`timescale 1ns/1ps
module tb_fu_reg_dep_matrix;
    localparam int FU_N  = 8;
    localparam int REG_N = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [FU_N-1:0]  iss_fu = '0;
    logic [REG_N-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [FU_N-1:0]  wb_fu = '0;
    logic             iss_stall;
    logic [FU_N-1:0]  wait_a, wait_b, fu_busy;
    logic [REG_N-1:0] rd_pending, wr_pending;

    fu_reg_dep_matrix #(.FU_N(FU_N), .REG_N(REG_N)) dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .wb_fu(wb_fu), .iss_stall(iss_stall), .wait_a(wait_a), .wait_b(wait_b),
        .rd_pending(rd_pending), .wr_pending(wr_pending), .fu_busy(fu_busy)
    );

    always #10 clk = ~clk;

    typedef struct {
        string            req;
        int               due;
        bit               comb;
        logic             stall;
        logic [FU_N-1:0]  wa, wb;
        logic [REG_N-1:0] rd, wr;
        logic [FU_N-1:0]  busy;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;

    logic [REG_N-1:0] m_nr[FU_N], m_nw[FU_N], m_lw[FU_N];
    logic [FU_N-1:0]  m_busy = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops items due this cycle in the low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.comb) begin
                    if (iss_stall !== it.stall || wait_a !== it.wa || wait_b !== it.wb) begin
                        errors++;
                        $display("FAIL %s cyc=%0d stall=%0b exp %0b wait_a=%h exp %h wait_b=%h exp %h",
                                 it.req, cyc, iss_stall, it.stall, wait_a, it.wa, wait_b, it.wb);
                    end
                end else begin
                    if (rd_pending !== it.rd || wr_pending !== it.wr || fu_busy !== it.busy) begin
                        errors++;
                        $display("FAIL %s cyc=%0d rd=%h exp %h wr=%h exp %h busy=%h exp %h",
                                 it.req, cyc, rd_pending, it.rd, wr_pending, it.wr, fu_busy, it.busy);
                    end
                end
            end
        end
    end

    // driver: applies one cycle of stimulus and queues expectations
    task automatic step(input string req, input bit v, input int fu,
                        input int sa, input int sb, input int d,
                        input logic [FU_N-1:0] wbm);
        logic [FU_N-1:0]  u;
        logic [REG_N-1:0] va, vb, vd;
        item_t ci, si;
        bit acc;
        @(negedge clk);
        #1;
        u  = (fu >= 0) ? (FU_N'(1) << fu) : '0;
        va = (sa >= 0) ? (REG_N'(1) << sa) : '0;
        vb = (sb >= 0) ? (REG_N'(1) << sb) : '0;
        vd = (d  >= 0) ? (REG_N'(1) << d)  : '0;
        iss_valid = v; iss_fu = u; iss_src_a = va; iss_src_b = vb; iss_dst = vd; wb_fu = wbm;
        ci = '{req: req, due: cyc, comb: 1'b1, stall: v && ((m_busy & u) != '0),
               wa: '0, wb: '0, rd: '0, wr: '0, busy: '0};
        for (int f = 0; f < FU_N; f++) begin
            if (!wbm[f] && (m_lw[f] & va) != '0) ci.wa[f] = 1'b1;
            if (!wbm[f] && (m_lw[f] & vb) != '0) ci.wb[f] = 1'b1;
        end
        q.push_back(ci);
        acc = v && (u != '0) && !ci.stall;
        for (int f = 0; f < FU_N; f++) begin
            if (wbm[f] && m_busy[f]) begin
                m_busy[f] = 1'b0; m_nr[f] = '0; m_nw[f] = '0; m_lw[f] = '0;
            end else if (acc && u[f]) begin
                m_busy[f] = 1'b1; m_nr[f] = va | vb; m_nw[f] = vd; m_lw[f] = vd;
            end else if (acc) begin
                m_lw[f] = m_lw[f] & ~vd;
            end
        end
        si = '{req: req, due: cyc + 1, comb: 1'b0, stall: 1'b0, wa: '0, wb: '0,
               rd: '0, wr: '0, busy: m_busy};
        for (int f = 0; f < FU_N; f++) begin
            si.rd = si.rd | m_nr[f];
            si.wr = si.wr | m_nw[f];
        end
        q.push_back(si);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired cyc=%0d exp queue empty", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int f = 0; f < FU_N; f++) begin
            m_nr[f] = '0; m_nw[f] = '0; m_lw[f] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, -1, -1, -1, -1, '0);
        // R10: rename example
        step("R10", 1, 2, 2, 3, 1, '0);       // MUL r1,r2,r3 on unit 2
        step("R10", 1, 0, 1, 3, 4, '0);       // ADD r4,r1,r3 waits on unit 2
        step("R10", 1, 1, 5, 6, 1, '0);       // ADD r1,r5,r6 takes the mark
        step("R10", 1, 3, 1, 4, 7, '0);       // reader of r1 waits on unit 1, r4 on unit 0
        // R7: busy unit refused
        step("R7", 1, 1, 9, 10, 11, '0);
        step("R7", 1, 3, 1, 2, 12, '0);
        // R8: no valid, no effect
        step("R8", 0, 4, 1, 4, 20, '0);
        // R4: lookup without valid still reports
        step("R4", 0, -1, 7, 2, -1, '0);
        // R5: unit 1 writes back while unit 4 reads r1
        step("R5", 1, 4, 1, 4, 13, 8'b0000_0010);
        // R6: retire the rest, readers then see nobody
        step("R6", 0, -1, -1, -1, -1, 8'b0000_1101);
        step("R6", 0, -1, 1, 7, -1, '0);
        // R11: write-back to idle unit 5
        step("R11", 0, -1, -1, -1, -1, 8'b0010_0000);
        // R9: source equal to destination
        step("R9", 1, 6, 9, -1, 9, '0);
        step("R9", 1, 5, 9, 0, 9, '0);
        step("R9", 1, 7, 9, 13, 14, '0);
        // R2/R3: retire all, then fill every unit with varied patterns
        step("R6", 0, -1, -1, -1, -1, 8'hFF);
        for (int i = 0; i < FU_N; i++)
            step("R2", 1, i, (i * 7 + 3) % REG_N, (i * 3) % REG_N, (i * 5 + 2) % 4, '0);
        for (int i = 0; i < FU_N; i++)
            step("R3", 0, -1, i % 4, (i * 5) % REG_N, -1, FU_N'(1) << i);
        step("R1", 0, -1, -1, -1, -1, '0);
        step("R1", 0, -1, -1, -1, -1, '0);
        while (q.size() > 0) @(negedge clk);
        #8;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule